// File: doc/BRIEF.md
# System-Management Memory Window Decoder

This block sits in the memory request path of a host bridge and decides, for each memory transaction, whether it falls into one of three regions reserved for system-management code. Those regions are a fixed low window of 128 KB, a high alias of that low window near the top of the 4 GB space, and a segment carved from the top of usable DRAM just under the memory reserved for integrated graphics. For every accepted request the block reports which window was hit. It also reports whether the access must be refused and which DRAM address the request should use.

The high alias is translated onto the low window: its 17 offset bits are kept and the low window's base replaces its upper bits. The low window and the top-of-memory segment are not translated. The bounds of the top-of-memory segment are not fixed. They are recomputed from the programmed top of low DRAM, the graphics-reserved size and a segment-size code, and they are held in a register that follows the configuration. Requests enter through a valid/ready handshake. The decision comes back one cycle later through a registered response stage, and that stage stalls under back-pressure.

Top module: `smram_decode`

## Requirements
- R1: When the low window is enabled, an address from 0x000A_0000 to 0x000B_FFFF hits it (`rsp_hit_comp`=1), and an allowed access keeps its address unchanged on `rsp_dram_addr`.
- R2: When the high window is enabled, an address from 0xFEDA_0000 to 0xFEDB_FFFF hits it (`rsp_hit_high`=1). An allowed access is sent to 0x000A_0000 OR (address AND 0x1_FFFF).
- R3: `cfg_tseg_sel` selects the segment size: 2'b00 gives 1 MB, 2'b01 gives 2 MB and 2'b10 gives 8 MB. The segment covers megabyte numbers (address >> 20) from top−size up to but not including top, where top = `cfg_tolud_mb` − `cfg_stolen_mb`. A hit sets `rsp_hit_tseg`=1, and an allowed access keeps its address.
- R4: The top-of-memory segment never hits when `cfg_tseg_sel`=2'b11, or when `cfg_tolud_mb` < `cfg_stolen_mb` + size.
- R5: A window whose enable input (`cfg_comp_en`, `cfg_high_en`, `cfg_tseg_en`) is low never reports a hit.
- R6: At most one hit flag is set. If windows overlap, the top-of-memory segment wins over the high window, and the high window wins over the low window.
- R7: A request from an I/O master (`req_io`=1) that hits any window is blocked.
- R8: A processor request that hits a window while `smm_act`=0 is blocked. A blocked response has `rsp_dram_vld`=0 and `rsp_dram_addr`=0.
- R9: An address outside every enabled window gives no hit and no block, `rsp_dram_vld`=1, and the address unchanged.
- R10: A request accepted at a rising edge (`req_valid` and `req_ready` both high) produces `rsp_valid`=1 after that edge. `req_ready` = !`rsp_valid` OR `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, every response output holds its value.
- R11: A request accepted at the first rising edge after a configuration change is decoded with the previous segment bounds. Requests accepted from the second edge onward use the new bounds.
- R12: While `rst_n` is low, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Transaction address |
| req_io | input | 1 | 1 = I/O master, 0 = processor |
| smm_act | input | 1 | Processor is in system-management mode |
| cfg_comp_en | input | 1 | Low window enable |
| cfg_high_en | input | 1 | High alias enable |
| cfg_tseg_en | input | 1 | Top-of-memory segment enable |
| cfg_tseg_sel | input | 2 | Segment size code |
| cfg_tolud_mb | input | ADDR_W-20 | Top of low usable DRAM in MB |
| cfg_stolen_mb | input | ADDR_W-20 | Graphics-reserved size in MB |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hit_comp | output | 1 | Low window hit |
| rsp_hit_high | output | 1 | High alias hit |
| rsp_hit_tseg | output | 1 | Segment hit |
| rsp_blocked | output | 1 | Access refused |
| rsp_dram_vld | output | 1 | DRAM address usable |
| rsp_dram_addr | output | ADDR_W | Translated DRAM address |

## Verification
The only internal state is the segment-bounds register and the response register. A stale or wrong segment bound shows up on the first request aimed at an address next to the segment's lower or upper edge, and it appears in the cycle after that request is accepted. The sweep therefore places addresses at both edges of every window in many configurations. A response register that loses its value under a stall shows on the port during the held cycles. An error in ordering or gating shows as two hit flags at once, or as a refused hit that still carries a usable address.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam int unsigned WIN_SH = 17;
  localparam int unsigned MB_SH  = 20;

  localparam logic [31:0] COMP_BASE = 32'h000A_0000;
  localparam logic [31:0] HIGH_BASE = 32'hFEDA_0000;

  typedef enum logic [1:0] {
    TSZ_1M  = 2'b00,
    TSZ_2M  = 2'b01,
    TSZ_8M  = 2'b10,
    TSZ_RSV = 2'b11
  } tseg_sz_e;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_COMP = 2'd1,
    WIN_HIGH = 2'd2,
    WIN_TSEG = 2'd3
  } win_e;

  // segment size in megabytes, zero for the reserved code
  function automatic logic [3:0] tseg_mb(input tseg_sz_e sel);
    case (sel)
      TSZ_1M:  tseg_mb = 4'd1;
      TSZ_2M:  tseg_mb = 4'd2;
      TSZ_8M:  tseg_mb = 4'd8;
      default: tseg_mb = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/smram_tseg_bounds.sv
module smram_tseg_bounds
  import smram_pkg::*;
#(
  parameter int MB_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      sel,
  input  logic [MB_W-1:0] tolud_mb,
  input  logic [MB_W-1:0] stolen_mb,
  output logic            bnd_vld,
  output logic [MB_W-1:0] bnd_base,
  output logic [MB_W-1:0] bnd_top
);

  logic [MB_W:0]   sz_w;
  logic [MB_W:0]   top_w;
  logic [MB_W:0]   base_w;
  logic            vld_d;
  logic [MB_W-1:0] base_d;
  logic [MB_W-1:0] top_d;
  logic            upd_en;

  // next-state: bounds from the configuration, with borrow detection
  always_comb begin
    sz_w   = (MB_W+1)'(tseg_mb(tseg_sz_e'(sel)));
    top_w  = {1'b0, tolud_mb} - {1'b0, stolen_mb};
    base_w = top_w - sz_w;
    vld_d  = en && (tseg_sz_e'(sel) != TSZ_RSV) && !top_w[MB_W] && !base_w[MB_W];
    top_d  = top_w[MB_W-1:0];
    base_d = base_w[MB_W-1:0];
    upd_en = (vld_d != bnd_vld) || (base_d != bnd_base) || (top_d != bnd_top);
  end

  // register: load only when the computed bounds differ
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_vld  <= 1'b0;
      bnd_base <= '0;
      bnd_top  <= '0;
    end else if (upd_en) begin
      bnd_vld  <= vld_d;
      bnd_base <= base_d;
      bnd_top  <= top_d;
    end
  end

endmodule

// File: rtl/smram_classify.sv
module smram_classify
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MB_W   = ADDR_W - MB_SH
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              comp_en,
  input  logic              high_en,
  input  logic              tseg_vld,
  input  logic [MB_W-1:0]   tseg_base,
  input  logic [MB_W-1:0]   tseg_top,
  output win_e              win,
  output logic [ADDR_W-1:0] map_addr
);

  localparam int KEY_W = ADDR_W - WIN_SH;
  localparam logic [ADDR_W-1:0] COMP_A = ADDR_W'(COMP_BASE);
  localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(HIGH_BASE);
  localparam logic [KEY_W-1:0]  COMP_KEY = COMP_A[ADDR_W-1:WIN_SH];
  localparam logic [KEY_W-1:0]  HIGH_KEY = HIGH_A[ADDR_W-1:WIN_SH];

  logic [MB_W-1:0]  addr_mb;
  logic [KEY_W-1:0] addr_key;
  logic             in_comp;
  logic             in_high;
  logic             in_tseg;

  always_comb begin
    addr_mb  = addr[ADDR_W-1:MB_SH];
    addr_key = addr[ADDR_W-1:WIN_SH];
    in_comp  = comp_en && (addr_key == COMP_KEY);
    in_high  = high_en && (addr_key == HIGH_KEY);
    in_tseg  = tseg_vld && (addr_mb >= tseg_base) && (addr_mb < tseg_top);

    // fixed ordering: segment, then high alias, then low window
    if (in_tseg) begin
      win      = WIN_TSEG;
      map_addr = addr;
    end else if (in_high) begin
      win      = WIN_HIGH;
      map_addr = {COMP_KEY, addr[WIN_SH-1:0]};
    end else if (in_comp) begin
      win      = WIN_COMP;
      map_addr = addr;
    end else begin
      win      = WIN_NONE;
      map_addr = addr;
    end
  end

endmodule

// File: rtl/smram_decode.sv
module smram_decode
  import smram_pkg::*;
#(
  parameter  int ADDR_W = 32,
  localparam int MB_W   = ADDR_W - MB_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic              smm_act,
  input  logic              cfg_comp_en,
  input  logic              cfg_high_en,
  input  logic              cfg_tseg_en,
  input  logic [1:0]        cfg_tseg_sel,
  input  logic [MB_W-1:0]   cfg_tolud_mb,
  input  logic [MB_W-1:0]   cfg_stolen_mb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit_comp,
  output logic              rsp_hit_high,
  output logic              rsp_hit_tseg,
  output logic              rsp_blocked,
  output logic              rsp_dram_vld,
  output logic [ADDR_W-1:0] rsp_dram_addr
);

  logic              bnd_vld;
  logic [MB_W-1:0]   bnd_base;
  logic [MB_W-1:0]   bnd_top;
  win_e              win;
  logic [ADDR_W-1:0] map_addr;

  logic              accept;
  logic              blk_d;
  logic              hc_d, hh_d, ht_d, dvld_d;
  logic [ADDR_W-1:0] daddr_d;

  smram_tseg_bounds #(.MB_W(MB_W)) u_bounds (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_tseg_en),
    .sel       (cfg_tseg_sel),
    .tolud_mb  (cfg_tolud_mb),
    .stolen_mb (cfg_stolen_mb),
    .bnd_vld   (bnd_vld),
    .bnd_base  (bnd_base),
    .bnd_top   (bnd_top)
  );

  smram_classify #(.ADDR_W(ADDR_W), .MB_W(MB_W)) u_class (
    .addr      (req_addr),
    .comp_en   (cfg_comp_en),
    .high_en   (cfg_high_en),
    .tseg_vld  (bnd_vld),
    .tseg_base (bnd_base),
    .tseg_top  (bnd_top),
    .win       (win),
    .map_addr  (map_addr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  // next-state for the response stage
  always_comb begin
    hc_d    = (win == WIN_COMP);
    hh_d    = (win == WIN_HIGH);
    ht_d    = (win == WIN_TSEG);
    blk_d   = (win != WIN_NONE) && (req_io || !smm_act);
    dvld_d  = !blk_d;
    daddr_d = blk_d ? '0 : map_addr;
  end

  // response valid: advances whenever the stage can move
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
    end
  end

  // response payload: loads only on an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit_comp  <= 1'b0;
      rsp_hit_high  <= 1'b0;
      rsp_hit_tseg  <= 1'b0;
      rsp_blocked   <= 1'b0;
      rsp_dram_vld  <= 1'b0;
      rsp_dram_addr <= '0;
    end else if (accept) begin
      rsp_hit_comp  <= hc_d;
      rsp_hit_high  <= hh_d;
      rsp_hit_tseg  <= ht_d;
      rsp_blocked   <= blk_d;
      rsp_dram_vld  <= dvld_d;
      rsp_dram_addr <= daddr_d;
    end
  end

endmodule

// File: rtl/smram_decode_chk.sv
module smram_decode_chk #(
  parameter int ADDR_W = 32,
  parameter int MB_W   = ADDR_W - 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_io,
  input logic              smm_act,
  input logic              cfg_comp_en,
  input logic              cfg_high_en,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit_comp,
  input logic              rsp_hit_high,
  input logic              rsp_hit_tseg,
  input logic              rsp_blocked,
  input logic              rsp_dram_vld,
  input logic [ADDR_W-1:0] rsp_dram_addr
);

  localparam logic [ADDR_W-1:0] LOW_A = ADDR_W'(32'h000A_0000);

  logic any_hit;
  assign any_hit = rsp_hit_comp || rsp_hit_high || rsp_hit_tseg;

  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_hit_tseg, rsp_hit_high, rsp_hit_comp}));

  // R7
  io_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_io) |=> (!any_hit || rsp_blocked));

  // R8
  smm_off_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !smm_act) |=> (!any_hit || rsp_blocked));

  // R8
  refused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_blocked) |-> (any_hit && !rsp_dram_vld && rsp_dram_addr == '0));

  // R5
  low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_comp_en) |=> !rsp_hit_comp);

  // R5
  high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_high_en) |=> !rsp_hit_high);

  // R2
  high_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit_high && !rsp_blocked) |->
      (rsp_dram_addr[ADDR_W-1:17] == LOW_A[ADDR_W-1:17]));

  // R10
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dram_addr) &&
      $stable(rsp_blocked) && $stable({rsp_hit_tseg, rsp_hit_high, rsp_hit_comp})));

endmodule

bind smram_decode smram_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_io        (req_io),
  .smm_act       (smm_act),
  .cfg_comp_en   (cfg_comp_en),
  .cfg_high_en   (cfg_high_en),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_hit_comp  (rsp_hit_comp),
  .rsp_hit_high  (rsp_hit_high),
  .rsp_hit_tseg  (rsp_hit_tseg),
  .rsp_blocked   (rsp_blocked),
  .rsp_dram_vld  (rsp_dram_vld),
  .rsp_dram_addr (rsp_dram_addr)
);

// File: tb/smram_decode_tb.sv
module smram_decode_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_io, smm_act;
  logic [31:0] req_addr;
  logic        cfg_comp_en, cfg_high_en, cfg_tseg_en;
  logic [1:0]  cfg_tseg_sel;
  logic [11:0] cfg_tolud_mb, cfg_stolen_mb;
  logic        rsp_valid, rsp_ready;
  logic        rsp_hit_comp, rsp_hit_high, rsp_hit_tseg, rsp_blocked, rsp_dram_vld;
  logic [31:0] rsp_dram_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  smram_decode #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .smm_act(smm_act),
    .cfg_comp_en(cfg_comp_en), .cfg_high_en(cfg_high_en), .cfg_tseg_en(cfg_tseg_en),
    .cfg_tseg_sel(cfg_tseg_sel), .cfg_tolud_mb(cfg_tolud_mb), .cfg_stolen_mb(cfg_stolen_mb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit_comp(rsp_hit_comp),
    .rsp_hit_high(rsp_hit_high), .rsp_hit_tseg(rsp_hit_tseg), .rsp_blocked(rsp_blocked),
    .rsp_dram_vld(rsp_dram_vld), .rsp_dram_addr(rsp_dram_addr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one request, checked one cycle after acceptance
  task automatic run_req(input longint a, input bit io, input bit smm);
    longint top, sz, base, amb, ea;
    bit tok, raw_t, rc, rh, ht, hh, hc, any, blk, ten_ok;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[31:0]; req_io = io; smm_act = smm;
    @(negedge clk);
    req_valid = 1'b0;
    sz     = (cfg_tseg_sel == 2'd0) ? 1 : (cfg_tseg_sel == 2'd1) ? 2 : (cfg_tseg_sel == 2'd2) ? 8 : 0;
    top    = longint'(cfg_tolud_mb) - longint'(cfg_stolen_mb);
    base   = top - sz;
    amb    = a >> 20;
    ten_ok = (cfg_tseg_sel != 2'd3) && (base >= 0);
    raw_t  = ten_ok && amb >= base && amb < top;
    tok    = cfg_tseg_en && raw_t;
    rc     = a >= 64'h000A_0000 && a <= 64'h000B_FFFF;
    rh     = a >= 64'hFEDA_0000 && a <= 64'hFEDB_FFFF;
    ht     = tok;
    hh     = !ht && cfg_high_en && rh;
    hc     = !ht && !hh && cfg_comp_en && rc;
    any    = ht || hh || hc;
    blk    = any && (io || !smm);
    ea     = blk ? 0 : hh ? (64'h000A_0000 | (a & 64'h1_FFFF)) : a;
    if ((raw_t && (rc || rh)) || (rc && rh)) tag = "R6";
    else if (ht) tag = "R3";
    else if (hh) tag = "R2";
    else if (hc) tag = "R1";
    else if (rc || rh || (raw_t && !cfg_tseg_en)) tag = "R5";
    else if ((amb >= base && amb < top && cfg_tseg_en) || (cfg_tseg_sel == 2'd3 && amb < top && amb >= top - 1)) tag = "R4";
    else tag = "R9";
    chk(rsp_valid == 1'b1, "R10", "rsp_valid", rsp_valid, 1);
    chk({rsp_hit_tseg, rsp_hit_high, rsp_hit_comp} == {ht, hh, hc}, tag, "hits",
        {rsp_hit_tseg, rsp_hit_high, rsp_hit_comp}, {ht, hh, hc});
    chk(rsp_blocked == blk, io ? "R7" : (any ? "R8" : "R9"), "blocked", rsp_blocked, blk);
    chk(rsp_dram_vld == !blk, blk ? "R8" : "R9", "dram_vld", rsp_dram_vld, !blk);
    chk(rsp_dram_addr == ea[31:0], blk ? "R8" : (hh ? "R2" : tag), "dram_addr",
        rsp_dram_addr, ea);
  endtask

  task automatic set_cfg(input bit ce, input bit he, input bit te, input logic [1:0] sel,
                         input int tol, input int stl);
    @(negedge clk);
    cfg_comp_en = ce; cfg_high_en = he; cfg_tseg_en = te; cfg_tseg_sel = sel;
    cfg_tolud_mb = 12'(tol); cfg_stolen_mb = 12'(stl);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=%0h exp=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tols[3]   = '{1, 64, 4080};
    int stols[3]  = '{0, 8, 32};
    longint fixed_a[9] = '{64'h9_FFFF, 64'hA_0000, 64'hB_FFFF, 64'hC_0000,
                           64'hFED9_FFFF, 64'hFEDA_0000, 64'hFEDA_1234,
                           64'hFEDB_FFFF, 64'hFEDC_0000};
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_io = 1'b0; smm_act = 1'b0;
    rsp_ready = 1'b1; cfg_comp_en = 1'b0; cfg_high_en = 1'b0; cfg_tseg_en = 1'b0;
    cfg_tseg_sel = 2'd0; cfg_tolud_mb = '0; cfg_stolen_mb = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 1'b0, "R12", "rsp_valid in reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R12", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;

    // sweep of configurations, edge addresses, requesters and enables
    for (int s = 0; s < 4; s++) begin
      for (int ti = 0; ti < 3; ti++) begin
        for (int si = 0; si < 3; si++) begin
          for (int m = 0; m < 8; m++) begin
            longint top, bse;
            set_cfg(m[0], m[1], m[2], 2'(s), tols[ti], stols[si]);
            top = longint'(tols[ti] - stols[si]);
            bse = top - ((s == 0) ? 1 : (s == 1) ? 2 : 8);
            for (int k = 0; k < 14; k++) begin
              longint a;
              if (k < 9) a = fixed_a[k];
              else case (k)
                9:  a = ((bse << 20) - 1) & 64'hFFFF_FFFF;
                10: a = (bse << 20) & 64'hFFFF_FFFF;
                11: a = ((bse << 20) + 64'h1_2345) & 64'hFFFF_FFFF;
                12: a = ((top << 20) - 1) & 64'hFFFF_FFFF;
                default: a = (top << 20) & 64'hFFFF_FFFF;
              endcase
              for (int r = 0; r < 4; r++) run_req(a, r[0], r[1]);
            end
          end
        end
      end
    end

    // R10 back-pressure: held response, then the waiting request
    set_cfg(1'b1, 1'b0, 1'b0, 2'd0, 64, 0);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h000A_1000; req_io = 1'b0; smm_act = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10", "req_ready stalled", req_ready, 0);
    req_addr = 32'h0000_1234;
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_hit_comp, "R10", "held hit", rsp_hit_comp, 1);
    chk(rsp_dram_addr == 32'h000A_1000, "R10", "held addr", rsp_dram_addr, 32'h000A_1000);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !rsp_hit_comp && rsp_dram_addr == 32'h0000_1234, "R10", "next addr",
        rsp_dram_addr, 32'h0000_1234);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "drained", rsp_valid, 0);

    // R11 configuration change timing
    set_cfg(1'b0, 1'b0, 1'b1, 2'd0, 64, 0);
    run_req(64'h03F0_0000, 1'b0, 1'b1);
    @(negedge clk);
    cfg_tolud_mb = 12'd32;
    req_valid = 1'b1; req_addr = 32'h03F0_0000; req_io = 1'b0; smm_act = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_hit_tseg == 1'b1, "R11", "old bounds used", rsp_hit_tseg, 1);
    run_req(64'h03F0_0000, 1'b0, 1'b1);
    chk(rsp_hit_tseg == 1'b0, "R11", "new bounds used", rsp_hit_tseg, 0);
    run_req(64'h01F0_0000, 1'b0, 1'b1);
    chk(rsp_hit_tseg == 1'b1, "R11", "new segment hit", rsp_hit_tseg, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule